// File: doc/BRIEF.md
# GPIO Port Group with Edge Interrupts and Group Summary

This block serves one group of up to eight general-purpose pins. Software reaches it through a small word-wide register bus. One register both sets the output pin levels and returns the input pin levels. A second register holds, for each pin, an interrupt enable and a choice between rising and falling edge. A third register holds the interrupt flags. A fourth returns a single read-only summary bit.

Each input passes through a two-stage synchroniser. The block then compares the synchronised sample with the one taken a cycle earlier. When that comparison shows the selected edge, the pin's flag is set, whether or not the pin is enabled. The interrupt request and the group summary bit are the only places where enables act. Each is high while at least one flag is set and enabled, so clearing the flags drops both. A flag is cleared by writing 1 to its bit. An edge that arrives in the same cycle as the clear wins.

Top module: `gpio_grp_port`

## Requirements
- R1: After reset the output bits, the enable and edge-select bits and all flags are 0. `irq_o`, `grp_o` and `pin_out_o` are then low.
- R2: Offset 0 is the data register. Writing it loads bits 15–8 into the output latch, which drives `pin_out_o` (1 high, 0 low). The same bits read back unchanged. Write data in bits 7–0 is ignored.
- R3: Reading bits 7–0 at offset 0 returns the pin levels after a two-register synchroniser. A pin change shows up there from the second rising clock edge onward.
- R4: Offset 1 is the control register. Bit p (p in 0–7) selects the edge for pin p: 1 means falling, 0 means rising. Only the selected edge sets flag p, in the third rising clock edge after the pin changes. The opposite edge leaves the flag unchanged.
- R5: Flags are set by their selected edge even when the matching enable bit is 0. In that case `irq_o` stays low.
- R6: Bit 8+p at offset 1 enables pin p. `irq_o` is high exactly when some flag bit is 1 together with its enable bit.
- R7: Bit 0 at offset 3 reads the group summary, which also appears on `grp_o`. It follows the same enabled-flag condition as `irq_o`, and writes to offset 3 have no effect.
- R8: Offset 2 bits 7–0 hold the flags. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged.
- R9: When a flag's selected edge and a write-1 clear of that flag fall in the same clock cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in_i | input | 8 | Asynchronous pin levels |
| pin_out_o | output | 8 | Output latch driving the pins |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request |
| grp_o | output | 1 | Group summary flag |

## Verification
The assertions assume a single-cycle write strobe that is observed only on a rising edge. They also assume that any pin is held stable while reset is low, so that no edge appears to occur at reset release. The stimulus applies all bus and pin changes on the falling clock edge and keeps the pins low during reset. It waits four cycles after every pin change before reading flags, except in the one test that deliberately lines a clear write up with the cycle in which the flag is set.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_CTRL = 2'd1,
        OFS_FLAG = 2'd2,
        OFS_STAT = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prv_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prv;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = pin_i;
        st_d.s2  = st_q.s1;
        st_d.prv = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.s2;
    assign prv_o = st_q.prv;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_grp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [W-1:0]     out_o,
    output logic [W-1:0]     en_o,
    output logic [W-1:0]     fall_o,
    output logic [W-1:0]     clr_o
);
    localparam int unsigned HI = BUS_W / 2;

    typedef struct packed {
        logic [W-1:0] outv;
        logic [W-1:0] en;
        logic [W-1:0] fall;
    } cfg_t;

    cfg_t cf_d, cf_q;

    always_comb begin
        cf_d  = cf_q;
        clr_o = '0;
        if (wr_i) begin
            unique case (reg_ofs_e'(addr_i))
                OFS_DATA: cf_d.outv = wdata_i[HI +: W];
                OFS_CTRL: begin
                    cf_d.en   = wdata_i[HI +: W];
                    cf_d.fall = wdata_i[0 +: W];
                end
                OFS_FLAG: clr_o = wdata_i[0 +: W];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cf_q <= '0;
        else        cf_q <= cf_d;
    end

    assign out_o  = cf_q.outv;
    assign en_o   = cf_q.en;
    assign fall_o = cf_q.fall;
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] prv_i,
    input  logic [W-1:0] fall_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] hit_o,
    output logic [W-1:0] flag_o,
    output logic         pend_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } flg_t;

    flg_t fl_d, fl_q;
    logic [W-1:0] hit;

    for (genvar p = 0; p < W; p++) begin : g_edge
        always_comb begin
            if (fall_i[p]) hit[p] = prv_i[p] & ~lvl_i[p];
            else           hit[p] = lvl_i[p] & ~prv_i[p];
        end
    end

    always_comb begin
        fl_d      = fl_q;
        fl_d.flag = (fl_q.flag & ~clr_i) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign hit_o  = hit;
    assign flag_o = fl_q.flag;
    assign pend_o = |(fl_q.flag & en_i);
endmodule

// File: rtl/gpio_grp_port.sv
module gpio_grp_port
    import gpio_grp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_in_i,
    output logic [W-1:0]      pin_out_o,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o,
    output logic              grp_o
);
    localparam int unsigned HI = BUS_W / 2;

    logic [W-1:0] lvl_w, prv_w, out_w, en_w, fall_w, clr_w, hit_w, flag_w;
    logic         pend_w;
    logic         wr_w;

    assign wr_w = bus_sel_i & bus_wr_i;

    gpio_pin_sync #(.W(W)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in_i), .lvl_o(lvl_w), .prv_o(prv_w)
    );

    gpio_cfg_regs #(.W(W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_w), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .out_o(out_w), .en_o(en_w), .fall_o(fall_w),
        .clr_o(clr_w)
    );

    gpio_flag_bank #(.W(W)) flg_i (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w), .prv_i(prv_w), .fall_i(fall_w),
        .en_i(en_w), .clr_i(clr_w), .hit_o(hit_w), .flag_o(flag_w), .pend_o(pend_w)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (reg_ofs_e'(bus_addr_i))
            OFS_DATA: begin
                bus_rdata_o[0 +: W]  = lvl_w;
                bus_rdata_o[HI +: W] = out_w;
            end
            OFS_CTRL: begin
                bus_rdata_o[0 +: W]  = fall_w;
                bus_rdata_o[HI +: W] = en_w;
            end
            OFS_FLAG: bus_rdata_o[0 +: W] = flag_w;
            OFS_STAT: bus_rdata_o[0]      = pend_w;
            default:  ;
        endcase
    end

    assign pin_out_o = out_w;
    assign irq_o     = pend_w;
    assign grp_o     = pend_w;
endmodule

// File: rtl/gpio_grp_chk.sv
module gpio_grp_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] flags,
    input logic [W-1:0] hit,
    input logic [W-1:0] clr,
    input logic [W-1:0] en,
    input logic [W-1:0] pin_out,
    input logic         data_wr,
    input logic         irq,
    input logic         grp
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~$past(clr) & ~flags) == '0)); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hit) & ~flags) == '0)); // R9
    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags & ~$past(flags)) & ~$past(hit)) == '0)); // R4
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & en) != '0)); // R6
    AST_GRP_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        grp == irq); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(data_wr) |-> $stable(pin_out)); // R2
endmodule

bind gpio_grp_port gpio_grp_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .flags(flag_w), .hit(hit_w), .clr(clr_w),
    .en(en_w), .pin_out(pin_out_o),
    .data_wr(wr_w && (bus_addr_i == 2'd0)),
    .irq(irq_o), .grp(grp_o)
);

// File: tb/gpio_grp_port_tb_top.sv
module gpio_grp_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        bsel = 1'b0, bwr = 1'b0;
    logic [1:0]  baddr = '0;
    logic [15:0] bwdata = '0;
    logic [15:0] rdata;
    logic        irq, grp;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_grp_port dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in_i(pin_in), .pin_out_o(pin_out),
        .bus_sel_i(bsel), .bus_wr_i(bwr), .bus_addr_i(baddr),
        .bus_wdata_i(bwdata), .bus_rdata_o(rdata), .irq_o(irq), .grp_o(grp)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
        @(negedge clk);
        bsel = 1'b0; bwr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        baddr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  fpat [4];
        logic [7:0]  epat [5];
        fpat = '{8'h01, 8'h80, 8'h5A, 8'h00};
        epat = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 data", v, 16'h0000);
        rd(2'd1, v); chk("R1 ctrl", v, 16'h0000);
        rd(2'd2, v); chk("R1 flag", v, 16'h0000);
        chk("R1 irq/grp/out", {6'b0, irq, grp, pin_out}, 16'h0000);

        // R2 / R3 data register
        wr(2'd0, 16'hA5FF);
        chk("R2 pin_out", {8'h00, pin_out}, 16'h00A5);
        rd(2'd0, v); chk("R2 readback", v, 16'hA500);
        pin_in = 8'h3C;
        @(negedge clk);
        rd(2'd0, v); chk("R3 after two edges", v, 16'hA53C);
        pin_in = 8'h00;
        settle();
        wr(2'd2, 16'h00FF);

        // R4 / R5 edge sweep with enables off
        for (int p = 0; p < 8; p++) begin
            for (int f = 0; f < 2; f++) begin
                logic [7:0] m;
                m = 8'h01 << p;
                wr(2'd1, {8'h00, (f == 1) ? m : 8'h00});
                wr(2'd2, 16'h00FF);
                pin_in[p] = 1'b1; settle();
                rd(2'd2, v); chk("R4 after rise", v, (f == 1) ? 16'h0000 : {8'h00, m});
                pin_in[p] = 1'b0; settle();
                rd(2'd2, v); chk("R4 after fall", v, {8'h00, m});
                chk("R5 irq off while disabled", {15'b0, irq}, 16'h0000);
            end
        end

        // R6 / R7 enable masking sweep
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 5; j++) begin
                logic exp_p;
                wr(2'd1, 16'h0000);
                wr(2'd2, 16'h00FF);
                pin_in = fpat[i]; settle();
                pin_in = 8'h00;   settle();
                wr(2'd1, {epat[j], 8'h00});
                exp_p = |(fpat[i] & epat[j]);
                chk("R6 irq", {15'b0, irq}, {15'b0, exp_p});
                rd(2'd3, v); chk("R7 group bit", v, {15'b0, exp_p});
            end
        end

        // R7 read-only, R8 clear semantics
        wr(2'd1, 16'hFF00);
        wr(2'd2, 16'h00FF);
        pin_in = 8'hFF; settle(); pin_in = 8'h00; settle();
        wr(2'd3, 16'h0000);
        rd(2'd3, v); chk("R7 write ignored", v, 16'h0001);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); chk("R8 write zero keeps", v, 16'h00FF);
        wr(2'd2, 16'h000F);
        rd(2'd2, v); chk("R8 partial clear", v, 16'h00F0);
        wr(2'd2, 16'h00F0);
        chk("R8 irq drops", {14'b0, irq, grp}, 16'h0000);

        // R9 set beats a coincident clear
        wr(2'd1, 16'h0000);
        @(negedge clk) pin_in = 8'h04;
        @(negedge clk);
        @(negedge clk);
        bsel = 1'b1; bwr = 1'b1; baddr = 2'd2; bwdata = 16'h0004;
        @(negedge clk);
        bsel = 1'b0; bwr = 1'b0;
        rd(2'd2, v); chk("R9 set wins", v, 16'h0004);
        wr(2'd2, 16'h0004);
        rd(2'd2, v); chk("R9 later clear", v, 16'h0000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule